// File: doc/BRIEF.md
# Vectored 32-Source Interrupt Controller

The block collects up to 32 interrupt request lines and merges them onto two processor interrupt outputs: a normal one and a critical one. Each source can be set as edge- or level-sensitive, and can be steered to either output. Each source passes through a two-stage synchroniser first. The synchronised level then updates a status word. That word is qualified by an enable word and split by a critical-select word to drive the outputs.

Software reaches the block over a small register bus. The bus has a 4-bit word offset, separate read and write strobes and 32-bit data. Reads return data combinationally while the read strobe is high. Writes take effect at the clock edge on which the write strobe is sampled.

When the `VEC_EN` parameter is set, the block also computes a vector address for the first pending critical source. The scan direction is programmable and the stride is 512 bytes per position. The block has no state machine. All behaviour is held in the status, level-held and configuration registers. The outputs and the vector are derived combinationally from those registers.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: Offset map. The offsets are 0 status (write clears), 1 status-set, 2 enable, 3 critical-select, 4 polarity, 5 trigger, 6 masked-status, 7 vector and 8 vector-config. Enable, critical-select and trigger read back exactly as written. Offsets 9 to 15 read zero, and writes to them change nothing.
- R3: Input n maps to status bit (31 − n). With trigger bit = 1 the source is edge-sensitive. A rising edge of the synchronised input sets the status bit. The bit stays set after the input falls, until software clears it. An input held high does not set the bit again after a clear.
- R4: With trigger bit = 0 the source is level-sensitive. A rising synchronised input sets both the status bit and a level-held bit. A falling input clears both bits.
- R5: A write to offset 0 clears every status bit written as 1, then ORs the level-held bits back in. A write to offset 1 ORs the data into status.
- R6: Offset 6 reads status AND enable. Writes to offsets 6 and 7 are ignored.
- R7: The normal output is high exactly when (status AND enable AND NOT critical-select) is nonzero.
- R8: The critical output is high exactly when (status AND enable AND critical-select) is nonzero.
- R9: The vector is computed from the pending critical word (status AND enable AND critical-select). With vector-config bit 0 = 0, the scan finds the lowest set bit i of that word. The vector is then (vector-config with bits 1:0 cleared) + 512·i.
- R10: With vector-config bit 0 = 1, the scan finds the highest set bit i of the pending critical word. The vector is then (vector-config with bits 1:0 cleared) + 512·(31 − i).
- R11: A write to offset 8 stores the data with bit 1 forced to 0. Offset 7 reads zero whenever no critical source is pending.
- R12: The polarity register at offset 4 reads back as written and has no effect on status or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous interrupt request lines, input n on bit n |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_rd is low |
| irq_norm | output | 1 | Normal interrupt output |
| irq_crit | output | 1 | Critical interrupt output |

## Verification
The controller is driven with single pulses on edge sources, and with levels that are held and then dropped on level sources. Set and clear writes then separate sticky edge status from status that follows the level-held bits. Sources are placed on both the normal and the critical side, which shows that the output split depends on critical-select. Several vector-config values are used: both scan directions, a two-source pending pattern whose result differs by direction, and a clear of the first source so the scan moves on to the next one. These confirm the 512-byte stride and the bit-reversed position. A polarity write of all ones and writes to the read-only offsets show that neither one disturbs status or the outputs.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 4;

    typedef enum logic [AW-1:0] {
        OFS_STAT   = 4'd0,
        OFS_SET    = 4'd1,
        OFS_ENA    = 4'd2,
        OFS_CSEL   = 4'd3,
        OFS_POL    = 4'd4,
        OFS_TRIG   = 4'd5,
        OFS_MSTAT  = 4'd6,
        OFS_VEC    = 4'd7,
        OFS_VCFG   = 4'd8
    } reg_ofs_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pic_vecgen.sv
module pic_vecgen #(
    parameter int unsigned W  = 32,
    parameter int unsigned SH = 9
) (
    input  logic [W-1:0] crit_pend,
    input  logic [W-1:0] cfg,
    output logic [W-1:0] vec
);
    localparam int unsigned PW = $clog2(W);

    logic [PW-1:0] lo_idx, hi_idx, pos;
    logic [W-1:0]  base;

    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = W - 1; i >= 0; i--) if (crit_pend[i]) lo_idx = PW'(i);
        for (int i = 0; i < W; i++)      if (crit_pend[i]) hi_idx = PW'(i);
    end

    always_comb begin
        base = {cfg[W-1:2], 2'b00};
        pos  = cfg[0] ? PW'(W - 1) - hi_idx : lo_idx;
        vec  = (crit_pend == '0) ? '0 : base + (W'(pos) << SH);
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned STRIDE = 9,
    parameter bit          VEC_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_norm,
    output logic            irq_crit
);
    logic [NSRC-1:0] sync_raw, lvl_now, lvl_prev, rise, fall;
    logic [NSRC-1:0] stat_q, stat_d, held_q, held_d;
    logic [NSRC-1:0] ena_q, csel_q, pol_q, trig_q;
    logic [NSRC-1:0] vcfg_q, vec_w, crit_pend, norm_pend;
    logic            wr_stat, wr_set;

    pic_sync #(.W(NSRC), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (irq_in),
        .d_out(sync_raw)
    );

    // input n lands on status bit NSRC-1-n
    for (genvar n = 0; n < NSRC; n++) begin : g_map
        assign lvl_now[NSRC-1-n] = sync_raw[n];
    end

    assign rise    = lvl_now & ~lvl_prev;
    assign fall    = ~lvl_now & lvl_prev;
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_set  = reg_wr && (reg_addr == OFS_SET);

    always_comb begin
        stat_d = stat_q;
        held_d = held_q;
        if (wr_stat) stat_d = (stat_q & ~reg_wdata) | held_q;
        if (wr_set)  stat_d = stat_q | reg_wdata;
        for (int i = 0; i < NSRC; i++) begin
            if (trig_q[i]) begin
                if (rise[i]) stat_d[i] = 1'b1;
            end else begin
                if (rise[i]) begin
                    stat_d[i] = 1'b1;
                    held_d[i] = 1'b1;
                end
                if (fall[i]) begin
                    stat_d[i] = 1'b0;
                    held_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            stat_q   <= '0;
            held_q   <= '0;
            ena_q    <= '0;
            csel_q   <= '0;
            pol_q    <= '0;
            trig_q   <= '0;
        end else begin
            lvl_prev <= lvl_now;
            stat_q   <= stat_d;
            held_q   <= held_d;
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_ENA:  ena_q  <= reg_wdata;
                    OFS_CSEL: csel_q <= reg_wdata;
                    OFS_POL:  pol_q  <= reg_wdata;
                    OFS_TRIG: trig_q <= reg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign crit_pend = stat_q & ena_q & csel_q;
    assign norm_pend = stat_q & ena_q & ~csel_q;
    assign irq_norm  = |norm_pend;
    assign irq_crit  = |crit_pend;

    if (VEC_EN) begin : g_vec
        always_ff @(posedge clk) begin
            if (!rst_n)                              vcfg_q <= '0;
            else if (reg_wr && reg_addr == OFS_VCFG) vcfg_q <= reg_wdata & ~NSRC'(2);
        end

        pic_vecgen #(.W(NSRC), .SH(STRIDE)) u_vec (
            .crit_pend(crit_pend),
            .cfg      (vcfg_q),
            .vec      (vec_w)
        );

        // R11: stored config has bit 1 cleared
        a_r11_vcfg_store: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == OFS_VCFG) |=> vcfg_q == ($past(reg_wdata) & ~NSRC'(2)));
        // R9/R10: stride only moves bits at and above the stride position
        a_r9_stride_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
            irq_crit |-> vec_w[STRIDE-1:0] == {vcfg_q[STRIDE-1:2], 2'b00});
    end else begin : g_novec
        assign vcfg_q = '0;
        assign vec_w  = '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_STAT, OFS_SET: reg_rdata = stat_q;
                OFS_ENA:           reg_rdata = ena_q;
                OFS_CSEL:          reg_rdata = csel_q;
                OFS_POL:           reg_rdata = pol_q;
                OFS_TRIG:          reg_rdata = trig_q;
                OFS_MSTAT:         reg_rdata = stat_q & ena_q;
                OFS_VEC:           reg_rdata = vec_w;
                OFS_VCFG:          reg_rdata = vcfg_q;
                default:           reg_rdata = '0;
            endcase
        end
    end

    // R4: every level-held bit is also present in status
    a_r4_held_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & held_q) == held_q);
    // R3: edge-mode status bits stay set unless a status write clears them
    a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (stat_q & $past(stat_q & trig_q)) == $past(stat_q & trig_q));
    // R11: no pending critical source means a zero vector
    a_r11_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit |-> vec_w == '0);
    // R12: polarity write stores the data as given
    a_r12_pol_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_POL) |=> pol_q == $past(reg_wdata));
    // R7/R8: an output is high only with some enabled status bit
    a_r7_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm || irq_crit) |-> (stat_q & ena_q) != '0);
endmodule

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_norm, irq_crit;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    pic_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    // kind: 0 write, 1 read-compare, 2 set inputs and settle, 3 compare {crit,norm}
    localparam int NV = 60;
    localparam logic [73:0] TBL [NV] = '{
        {2'd1, 4'd0, 32'h0, 32'h0, 4'd1},                  // R1 status
        {2'd1, 4'd2, 32'h0, 32'h0, 4'd1},                  // R1 enable
        {2'd1, 4'd8, 32'h0, 32'h0, 4'd1},                  // R1 vector config
        {2'd3, 4'd0, 32'h0, 32'h0, 4'd1},                  // R1 outputs
        {2'd0, 4'd2, 32'hFFFFFFFF, 32'h0, 4'd2},
        {2'd1, 4'd2, 32'h0, 32'hFFFFFFFF, 4'd2},           // R2
        {2'd0, 4'd4, 32'h12345678, 32'h0, 4'd12},
        {2'd1, 4'd4, 32'h0, 32'h12345678, 4'd12},          // R12 readback
        {2'd0, 4'd9, 32'hDEADBEEF, 32'h0, 4'd2},
        {2'd1, 4'd9, 32'h0, 32'h0, 4'd2},                  // R2 unmapped
        {2'd1, 4'd15, 32'h0, 32'h0, 4'd2},                 // R2 unmapped
        {2'd0, 4'd5, 32'hF0000000, 32'h0, 4'd2},
        {2'd1, 4'd5, 32'h0, 32'hF0000000, 4'd2},           // R2 trigger
        {2'd0, 4'd3, 32'h0000FFFF, 32'h0, 4'd2},
        {2'd2, 4'd0, 32'h00000001, 32'h0, 4'd3},           // input 0, edge
        {2'd1, 4'd0, 32'h0, 32'h80000000, 4'd3},           // R3 bit mapping
        {2'd3, 4'd0, 32'h0, 32'h1, 4'd7},                  // R7 normal
        {2'd2, 4'd0, 32'h0, 32'h0, 4'd3},
        {2'd1, 4'd0, 32'h0, 32'h80000000, 4'd3},           // R3 sticky
        {2'd0, 4'd0, 32'h80000000, 32'h0, 4'd5},
        {2'd1, 4'd0, 32'h0, 32'h0, 4'd5},                  // R5 clear
        {2'd3, 4'd0, 32'h0, 32'h0, 4'd7},
        {2'd2, 4'd0, 32'h00000010, 32'h0, 4'd4},           // input 4, level
        {2'd1, 4'd0, 32'h0, 32'h08000000, 4'd4},           // R4 follow high
        {2'd0, 4'd0, 32'hFFFFFFFF, 32'h0, 4'd5},
        {2'd1, 4'd0, 32'h0, 32'h08000000, 4'd5},           // R5 held level kept
        {2'd2, 4'd0, 32'h0, 32'h0, 4'd4},
        {2'd1, 4'd0, 32'h0, 32'h0, 4'd4},                  // R4 follow low
        {2'd0, 4'd1, 32'h00000003, 32'h0, 4'd5},
        {2'd1, 4'd0, 32'h0, 32'h00000003, 4'd5},           // R5 set
        {2'd3, 4'd0, 32'h0, 32'h2, 4'd8},                  // R8 critical only
        {2'd0, 4'd2, 32'h00000001, 32'h0, 4'd6},
        {2'd1, 4'd6, 32'h0, 32'h00000001, 4'd6},           // R6 masked status
        {2'd0, 4'd2, 32'hFFFFFFFF, 32'h0, 4'd6},
        {2'd0, 4'd8, 32'h00010003, 32'h0, 4'd11},
        {2'd1, 4'd8, 32'h0, 32'h00010001, 4'd11},          // R11 bit 1 forced
        {2'd1, 4'd7, 32'h0, 32'h00013C00, 4'd10},          // R10 downward scan
        {2'd0, 4'd8, 32'h00020000, 32'h0, 4'd9},
        {2'd1, 4'd7, 32'h0, 32'h00020000, 4'd9},           // R9 upward scan
        {2'd0, 4'd0, 32'h00000001, 32'h0, 4'd9},
        {2'd1, 4'd7, 32'h0, 32'h00020200, 4'd9},           // R9 next source
        {2'd0, 4'd7, 32'hFFFFFFFF, 32'h0, 4'd6},
        {2'd1, 4'd7, 32'h0, 32'h00020200, 4'd6},           // R6 vector read-only
        {2'd0, 4'd6, 32'hFFFFFFFF, 32'h0, 4'd6},
        {2'd1, 4'd0, 32'h0, 32'h00000002, 4'd6},           // R6 masked read-only
        {2'd0, 4'd0, 32'h00000002, 32'h0, 4'd11},
        {2'd1, 4'd7, 32'h0, 32'h0, 4'd11},                 // R11 zero vector
        {2'd3, 4'd0, 32'h0, 32'h0, 4'd8},
        {2'd0, 4'd4, 32'hFFFFFFFF, 32'h0, 4'd12},
        {2'd3, 4'd0, 32'h0, 32'h0, 4'd12},                 // R12 no effect
        {2'd1, 4'd0, 32'h0, 32'h0, 4'd12},                 // R12 no effect
        {2'd2, 4'd0, 32'h80000000, 32'h0, 4'd8},           // input 31, level, critical
        {2'd3, 4'd0, 32'h0, 32'h2, 4'd8},                  // R8
        {2'd1, 4'd7, 32'h0, 32'h00020000, 4'd9},           // R9
        {2'd2, 4'd0, 32'h0, 32'h0, 4'd4},
        {2'd3, 4'd0, 32'h0, 32'h0, 4'd4},                  // R4 level drop
        {2'd2, 4'd0, 32'h00000002, 32'h0, 4'd3},           // input 1 edge, held high
        {2'd0, 4'd0, 32'h40000000, 32'h0, 4'd3},
        {2'd1, 4'd0, 32'h0, 32'h0, 4'd3},                  // R3 no re-set while high
        {2'd2, 4'd0, 32'h0, 32'h0, 4'd3}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %08h expected %08h", rq, act, exp);
        end
    endtask

    task automatic step(input logic [73:0] e);
        logic [1:0]  k;
        logic [3:0]  a;
        logic [31:0] d, x;
        int          rq;
        k = e[73:72]; a = e[71:68]; d = e[67:36]; x = e[35:4]; rq = int'(e[3:0]);
        @(negedge clk);
        case (k)
            2'd0: begin
                reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0;
            end
            2'd1: begin
                reg_addr = a; reg_rd = 1'b1;
                #1 check(reg_rdata, x, rq);
                reg_rd = 1'b0;
            end
            2'd2: begin
                irq_in = d;
                repeat (4) @(negedge clk);
            end
            default: check({30'd0, irq_crit, irq_norm}, x, rq);
        endcase
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) step(TBL[i]);

        // R1: reset in mid-run returns every register to zero
        step({2'd0, 4'd1, 32'hFFFFFFFF, 32'h0, 4'd1});
        step({2'd0, 4'd8, 32'h00001234, 32'h0, 4'd1});
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        step({2'd1, 4'd0, 32'h0, 32'h0, 4'd1});
        step({2'd1, 4'd2, 32'h0, 32'h0, 4'd1});
        step({2'd1, 4'd8, 32'h0, 32'h0, 4'd1});
        step({2'd3, 4'd0, 32'h0, 32'h0, 4'd1});
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule